// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the interrupt part of a multicycle processor's control unit. Whenever the control reaches the point between two instructions, it looks at the shared interrupt request line. If a request is present and interrupts are enabled, the normal fetch does not start. The block first raises an acknowledge toward the devices and waits for a device to place a handler address on the data bus. It then saves the address the processor was about to fetch into a dedicated kernel return register, clears the enable bit, switches to supervisor mode and loads the PC with the handler address.

The block also carries out three instructions once decode has recognised them: return-from-interrupt, enable-interrupts and disable-interrupts. Each arrives as a one-cycle strobe. Return-from-interrupt reloads the PC from the kernel return register, sets the enable bit and puts back the privilege mode that was in force when the interrupt was taken. If no device answers the acknowledge within a bounded number of cycles, the block gives up and branches to a fixed fallback handler. The datapath sees only a fetch-go strobe and a PC load port.

Top module: `irq_entry_seq`

## Requirements
- R1: While idle, a high `boundary_i` raises `fetch_go_o` in the same cycle unless `irq_i` and `ie_o` are both high, in which case the interrupt is taken and `fetch_go_o` stays low. A high `irq_i` without `boundary_i` starts no acknowledge.
- R2: From the cycle after an interrupt is taken, `kpc_o` holds the `pc_i` value present in the taking cycle. The privilege mode in force at that moment is kept for the later return.
- R3: `ie_o` reads 0 from the cycle after an interrupt is taken.
- R4: `supv_o` reads 1 from the cycle after an interrupt is taken.
- R5: `iack_o` is high from the cycle after the taking cycle through the cycle in which `vec_valid_i` is seen, and for no more than TIMEOUT cycles.
- R6: In the cycle after `vec_valid_i` is seen during acknowledge, `pc_load_o` is high for exactly one cycle and `pc_value_o` equals the `data_i` value sampled together with `vec_valid_i`. `iack_o` is then low.
- R7: If `vec_valid_i` stays low for TIMEOUT acknowledge cycles, `iack_o` drops and the next cycle loads the PC with DEFAULT_VEC.
- R8: A `reti_i` strobe while idle raises `pc_load_o` in the same cycle with `pc_value_o` equal to `kpc_o`. From the next cycle `ie_o` is 1 and `supv_o` equals the mode saved at interrupt entry.
- R9: An `ei_i` strobe sets `ie_o` from the next cycle and a `di_i` strobe clears it; when both arrive together, disable wins. Instruction strobes are ignored while an acknowledge or PC load is in progress.
- R10: A request held on `irq_i` while `ie_o` is 0 is not lost. It is taken at the first boundary at which `ie_o` reads 1; an enable strobe given in the same cycle as a boundary does not yet count for that boundary.
- R11: After reset, `ie_o`=0, `supv_o`=1, `kpc_o`=0, `iack_o`=0, `pc_load_o`=0, and the saved mode is user (0), so a return issued straight after reset enters user mode at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Control is between instructions and ready to fetch |
| irq_i | input | 1 | Shared interrupt request line |
| pc_i | input | AW | Address of the next instruction to fetch |
| data_i | input | AW | Data bus carrying the handler address |
| vec_valid_i | input | 1 | Device strobe: handler address valid on data_i |
| reti_i | input | 1 | Return-from-interrupt instruction strobe |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| fetch_go_o | output | 1 | Start the normal fetch at this boundary |
| iack_o | output | 1 | Interrupt acknowledge toward devices |
| pc_load_o | output | 1 | Load the PC with pc_value_o |
| pc_value_o | output | AW | New PC value |
| kpc_o | output | AW | Kernel return-address register |
| ie_o | output | 1 | Interrupt enable bit |
| supv_o | output | 1 | Supervisor mode bit |

## Verification
A corrupted sequencer state shows at the ports within one or two cycles. A stuck acknowledge state keeps `iack_o` high past TIMEOUT cycles. A missed return to idle suppresses `fetch_go_o` at the next boundary. A wrong captured vector appears as a bad `pc_value_o` in the single load cycle. A lost saved mode or return address stays hidden until the matching return, where `pc_value_o` and `supv_o` expose it in that cycle and the next. The bench therefore runs every acknowledge latency from zero up to the timeout, and it runs the entry and the return back to back, from user mode and from a nested supervisor handler.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_LOAD = 2'd2
  } seq_state_e;

  // True when the acknowledge cycle counted by cnt is the last permitted one.
  function automatic logic ack_window_done(input logic [31:0] cnt,
                                           input logic [31:0] limit);
    return (cnt + 32'd1) >= limit;
  endfunction

  // Next value of the enable bit; entry beats return beats disable beats enable.
  function automatic logic next_enable(input logic cur, input logic take,
                                       input logic reti, input logic en,
                                       input logic dis);
    if (take) return 1'b0;
    if (reti) return 1'b1;
    if (dis)  return 1'b0;
    if (en)   return 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/irq_ack_timer.sv
module irq_ack_timer #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  import irq_seq_pkg::*;

  localparam int unsigned CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i & ack_window_done(32'(cnt_q), 32'(TIMEOUT));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  // R5: the acknowledge window never counts past its limit
  assert_ack_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (32'(cnt_q) < TIMEOUT));

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    boundary_i,
  input  logic                    irq_i,
  input  logic                    ie_i,
  input  logic                    vec_valid_i,
  input  logic                    expired_i,
  input  logic                    reti_i,
  input  logic                    ei_i,
  input  logic                    di_i,
  output irq_seq_pkg::seq_state_e state_o,
  output logic                    take_o,
  output logic                    accept_o,
  output logic                    timeout_o,
  output logic                    reti_o,
  output logic                    ei_o,
  output logic                    di_o,
  output logic                    fetch_go_o
);
  import irq_seq_pkg::*;

  seq_state_e state_q, state_d;
  logic       idle;
  logic       op_ok;

  assign idle       = (state_q == ST_IDLE);
  assign take_o     = idle & boundary_i & irq_i & ie_i;
  assign fetch_go_o = idle & boundary_i & ~take_o;
  assign accept_o   = (state_q == ST_ACK) & vec_valid_i;
  assign timeout_o  = (state_q == ST_ACK) & ~vec_valid_i & expired_i;

  assign op_ok  = idle & ~take_o;
  assign reti_o = op_ok & reti_i;
  assign di_o   = op_ok & ~reti_i & di_i;
  assign ei_o   = op_ok & ~reti_i & ~di_i & ei_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take_o) state_d = ST_ACK;
      ST_ACK:  if (accept_o || timeout_o) state_d = ST_LOAD;
      ST_LOAD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R5: acknowledge begins right after the request is taken
  assert_take_enters_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (state_q == ST_ACK));

  // R6: a load is always followed by a return to idle
  assert_load_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          reti_i,
  input  logic          ei_i,
  input  logic          di_i,
  input  logic [AW-1:0] pc_i,
  output logic          ie_o,
  output logic          supv_o,
  output logic [AW-1:0] kpc_o
);
  import irq_seq_pkg::*;

  logic          ie_q;
  logic          supv_q;
  logic          smode_q;
  logic [AW-1:0] kpc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      supv_q  <= 1'b1;
      smode_q <= 1'b0;
      kpc_q   <= '0;
    end else begin
      ie_q <= next_enable(ie_q, take_i, reti_i, ei_i, di_i);
      if (take_i) begin
        kpc_q   <= pc_i;
        smode_q <= supv_q;
        supv_q  <= 1'b1;
      end else if (reti_i) begin
        supv_q  <= smode_q;
      end
    end
  end

  assign ie_o   = ie_q;
  assign supv_o = supv_q;
  assign kpc_o  = kpc_q;

  // R2: the return address is the PC presented when the request was taken
  assert_kpc_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (kpc_q == $past(pc_i)));

  // R3: entry clears the enable bit
  assert_ie_cleared_on_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !ie_q);

  // R4: entry raises the privilege level
  assert_supv_on_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> supv_q);

  // R8: return re-enables and puts back the saved mode
  assert_reti_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> (ie_q && (supv_q == $past(smode_q))));

  // R9: disable strobe clears the enable bit
  assert_di_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    di_i |=> !ie_q);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int unsigned AW          = 32,
  parameter int unsigned TIMEOUT     = 16,
  parameter logic [AW-1:0] DEFAULT_VEC = AW'(32'h0000_0100)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary_i,
  input  logic          irq_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] data_i,
  input  logic          vec_valid_i,
  input  logic          reti_i,
  input  logic          ei_i,
  input  logic          di_i,
  output logic          fetch_go_o,
  output logic          iack_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_value_o,
  output logic [AW-1:0] kpc_o,
  output logic          ie_o,
  output logic          supv_o
);
  import irq_seq_pkg::*;

  // Named internal events
  seq_state_e    state;
  logic          take_evt;
  logic          accept_evt;
  logic          timeout_evt;
  logic          reti_evt;
  logic          ei_evt;
  logic          di_evt;
  logic          ack_expired;
  logic          in_load;
  logic [AW-1:0] vec_q;

  irq_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary_i  (boundary_i),
    .irq_i       (irq_i),
    .ie_i        (ie_o),
    .vec_valid_i (vec_valid_i),
    .expired_i   (ack_expired),
    .reti_i      (reti_i),
    .ei_i        (ei_i),
    .di_i        (di_i),
    .state_o     (state),
    .take_o      (take_evt),
    .accept_o    (accept_evt),
    .timeout_o   (timeout_evt),
    .reti_o      (reti_evt),
    .ei_o        (ei_evt),
    .di_o        (di_evt),
    .fetch_go_o  (fetch_go_o)
  );

  irq_ack_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (iack_o),
    .expired_o (ack_expired)
  );

  irq_ctx_regs #(.AW(AW)) u_ctx (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take_evt),
    .reti_i (reti_evt),
    .ei_i   (ei_evt),
    .di_i   (di_evt),
    .pc_i   (pc_i),
    .ie_o   (ie_o),
    .supv_o (supv_o),
    .kpc_o  (kpc_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           vec_q <= '0;
    else if (accept_evt)  vec_q <= data_i;
    else if (timeout_evt) vec_q <= DEFAULT_VEC;
  end

  assign iack_o     = (state == ST_ACK);
  assign in_load    = (state == ST_LOAD);
  assign pc_load_o  = in_load | reti_evt;
  assign pc_value_o = in_load ? vec_q : kpc_o;

  // R1: no fetch starts while devices are being acknowledged
  assert_no_fetch_in_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |-> !fetch_go_o);

  // R5: acknowledge is visible the cycle after entry
  assert_iack_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> iack_o);

  // R6: the supplied vector is loaded next cycle
  assert_vector_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (pc_load_o && !iack_o && (pc_value_o == $past(data_i))));

  // R7: silence during acknowledge falls back to the default handler
  assert_default_on_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (pc_load_o && !iack_o && (pc_value_o == DEFAULT_VEC)));

  // R8: return loads the kernel return address
  assert_reti_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reti_evt |-> (pc_load_o && (pc_value_o == kpc_o)));

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

  localparam int unsigned AW = 16;
  localparam int unsigned T  = 4;
  localparam logic [AW-1:0] DEF = 16'h0040;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          boundary_i = 1'b0;
  logic          irq_i = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic [AW-1:0] data_i = '0;
  logic          vec_valid_i = 1'b0;
  logic          reti_i = 1'b0;
  logic          ei_i = 1'b0;
  logic          di_i = 1'b0;
  logic          fetch_go_o, iack_o, pc_load_o, ie_o, supv_o;
  logic [AW-1:0] pc_value_o, kpc_o;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq #(.AW(AW), .TIMEOUT(T), .DEFAULT_VEC(DEF)) u_dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .irq_i(irq_i),
    .pc_i(pc_i), .data_i(data_i), .vec_valid_i(vec_valid_i),
    .reti_i(reti_i), .ei_i(ei_i), .di_i(di_i),
    .fetch_go_o(fetch_go_o), .iack_o(iack_o), .pc_load_o(pc_load_o),
    .pc_value_o(pc_value_o), .kpc_o(kpc_o), .ie_o(ie_o), .supv_o(supv_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Enter an interrupt; the device answers on ack cycle d (d >= T: never).
  // Enable strobes driven during acknowledge must be ignored (R9).
  task automatic take_irq(input logic [AW-1:0] p, input logic [AW-1:0] v, input int d);
    int k = 0;
    bit got = 0;
    @(negedge clk); boundary_i = 1; irq_i = 1; pc_i = p; #1;
    chk("R1 no fetch when taken", 32'(fetch_go_o), 0);
    @(negedge clk); boundary_i = 0; pc_i = '0; #1;
    chk("R2 kpc saved", 32'(kpc_o), 32'(p));
    chk("R3 ie cleared", 32'(ie_o), 0);
    chk("R4 supervisor", 32'(supv_o), 1);
    while (!got && k < T) begin
      if (k > 0) begin @(negedge clk); #1; end
      chk("R5 iack held", 32'(iack_o), 1);
      ei_i = 1;
      if (k == d) begin vec_valid_i = 1; data_i = v; got = 1; end
      k++;
    end
    @(negedge clk); vec_valid_i = 0; data_i = '0; irq_i = 0; ei_i = 0; #1;
    chk("R5 iack released", 32'(iack_o), 0);
    if (got) begin
      chk("R6 load strobe", 32'(pc_load_o), 1);
      chk("R6 vector", 32'(pc_value_o), 32'(v));
    end else begin
      chk("R7 load strobe", 32'(pc_load_o), 1);
      chk("R7 default vector", 32'(pc_value_o), 32'(DEF));
    end
    chk("R9 ei ignored in ack", 32'(ie_o), 0);
    @(negedge clk); #1;
    chk("R6 single load", 32'(pc_load_o), 0);
  endtask

  task automatic do_reti(input logic [AW-1:0] exp_pc, input logic exp_mode);
    @(negedge clk); reti_i = 1; #1;
    chk("R8 reti load", 32'(pc_load_o), 1);
    chk("R8 reti pc", 32'(pc_value_o), 32'(exp_pc));
    @(negedge clk); reti_i = 0; #1;
    chk("R8 ie set", 32'(ie_o), 1);
    chk("R8 mode restored", 32'(supv_o), 32'(exp_mode));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11 ie", 32'(ie_o), 0);
    chk("R11 supv", 32'(supv_o), 1);
    chk("R11 kpc", 32'(kpc_o), 0);
    chk("R11 iack", 32'(iack_o), 0);
    chk("R11 pc_load", 32'(pc_load_o), 0);

    // Request while disabled: plain fetch, request stays on the line
    @(negedge clk); boundary_i = 1; irq_i = 1; #1;
    chk("R10 disabled fetch", 32'(fetch_go_o), 1);
    @(negedge clk); boundary_i = 0; #1;
    chk("R10 no ack while disabled", 32'(iack_o), 0);

    // Return straight after reset enters user mode at 0
    do_reti('0, 1'b0);
    chk("R11 user after reset reti", 32'(supv_o), 0);

    // Simultaneous enable and disable: disable wins
    @(negedge clk); ei_i = 1; di_i = 1; #1;
    @(negedge clk); ei_i = 0; di_i = 0; #1;
    chk("R9 di wins", 32'(ie_o), 0);
    // Enable in a boundary cycle does not count for that boundary
    @(negedge clk); ei_i = 1; boundary_i = 1; #1;
    chk("R10 enable same boundary", 32'(fetch_go_o), 1);
    @(negedge clk); ei_i = 0; boundary_i = 0; #1;
    chk("R9 ei sets", 32'(ie_o), 1);
    chk("R1 no ack without boundary", 32'(iack_o), 0);
    @(negedge clk); #1;
    chk("R1 still no ack", 32'(iack_o), 0);

    // Sweep every acknowledge latency, then the timeout
    for (int d = 0; d <= int'(T); d++) begin
      logic [AW-1:0] p, v;
      p = AW'(16'h1000 + d * 16'h0122);
      v = AW'(16'h2000 + d * 16'h0311);
      take_irq(p, v, d);
      do_reti(p, 1'b0);
    end

    // Ordinary boundary with no request
    @(negedge clk); boundary_i = 1; irq_i = 0; #1;
    chk("R1 plain fetch", 32'(fetch_go_o), 1);
    @(negedge clk); boundary_i = 0; #1;

    // Nested: handler re-enables, second entry saves supervisor mode
    take_irq(16'h3330, 16'h5000, 1);
    @(negedge clk); ei_i = 1; #1;
    @(negedge clk); ei_i = 0; #1;
    chk("R9 ei in handler", 32'(ie_o), 1);
    take_irq(16'h5004, 16'h6000, 2);
    do_reti(16'h5004, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule